// File: doc/BRIEF.md
# Single-Channel Register-Mapped Serial Master

This block is one channel of a synchronous serial master that software drives through five 32-bit word registers. A status register holds a one-hot choice among three attached devices and a 3-bit code for the shift clock rate. A control register holds the transfer length, the direction and a start bit. A data register holds the immediate word that is sent or received.

Software starts a transfer by writing the control register with the start bit set. The bit then reads back as 1 until the last bit has been shifted, after which the hardware clears it. Words are left-justified in the data register, so a 1-byte or 2-byte transfer uses the top of the word.

The select line stays asserted after a transfer ends and drops only when software clears it. A command byte can therefore be followed by a read of the answer within one selection. Two register slots are reserved for block transfers and are inert in this channel.

Top module: `serchan_top`

## Requirements
- R1: After reset, every register reads zero and `dev_sel`, `sclk` and `mosi` are all 0.
- R2: Status bits 9:7 hold the device select, with bit 7+i driving `dev_sel[i]`. A status write whose field has zero or one bit set replaces the field. A write with two or more bits set leaves the field unchanged. The field is not altered by transfers.
- R3: Status bits 6:4 hold the rate code. While a transfer runs, `sclk` has a period of 2^(code+1) system clocks for codes 0 to 6, and code 7 behaves like code 6. `sclk` is low whenever no transfer runs.
- R4: A control write with bit 0 set while idle starts a transfer. Control bit 0 then reads 1 for exactly nbits*2^(code+1) clock cycles after the write edge and 0 afterwards, where nbits is 8 times the byte count.
- R5: Control bits 5:4 hold the byte count minus one (0 gives 1 byte, 1 gives 2 bytes, 3 gives 4 bytes). Control bits 3:2 hold the direction, where 1 means write and any other value means read. Both fields read back as last accepted.
- R6: In a write, bits leave on `mosi` most-significant first, starting at data bit 31. `mosi` changes only at falling `sclk` edges and is stable while `sclk` is high.
- R7: In a read, `miso` is sampled at rising `sclk` edges and the received bits land left-justified in the data register, with all bits below them zero, by the time control bit 0 reads 0. `mosi` stays low throughout a read.
- R8: A control write while a transfer runs is ignored. It does not restart or lengthen the transfer, and it does not change the direction or length fields.
- R9: Offsets 0x04 and 0x08 read zero and ignore writes. The data register at 0x10 reads back the last written word until a read transfer completes. Undecoded offsets read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| dev_sel | output | 3 | Active-high device selects, at most one set |
| sclk | output | 1 | Serial shift clock, idle low |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
The bench builds the block with its default parameters: a 32-bit word, three devices, a 3-bit rate field and a highest divide code of 6. With these values, random transfers of 1, 2 and 4 bytes at codes 0 to 3 exercise full-word and partial left-justification while keeping runs short. Directed transfers at codes 6 and 7 reach the widest divider count and the clamp of the unused code. A device model answers on `miso` and captures `mosi`, so the sent bit order and the received word are compared against values computed from the requirements.

// File: rtl/serchan_pkg.sv
package serchan_pkg;
  // register byte offsets (fixed by software contract)
  localparam int OFS_STAT = 'h00;
  localparam int OFS_BLKA = 'h04;
  localparam int OFS_BLKL = 'h08;
  localparam int OFS_CTRL = 'h0C;
  localparam int OFS_DATA = 'h10;

  // field positions
  localparam int SEL_LSB   = 7;
  localparam int RATE_LSB  = 4;
  localparam int GO_BIT    = 0;
  localparam int DIR_LSB   = 2;
  localparam int DIR_W     = 2;
  localparam int LEN_LSB   = 4;

  typedef enum logic [DIR_W-1:0] {
    DIR_RX = 2'd0,
    DIR_TX = 2'd1
  } dir_e;
endpackage

// File: rtl/serchan_rstsync.sv
module serchan_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/serchan_clkgen.sv
module serchan_clkgen #(
  parameter int RATE_W   = 3,
  parameter int MAX_CODE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int CNT_W = (MAX_CODE > 0) ? MAX_CODE : 1;

  logic [RATE_W-1:0] code_eff;
  logic [RATE_W-1:0] shamt;
  logic [CNT_W-1:0]  cnt_limit;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    code_eff  = (rate > RATE_W'(MAX_CODE)) ? RATE_W'(MAX_CODE) : rate;
    shamt     = RATE_W'(MAX_CODE) - code_eff;
    cnt_limit = {CNT_W{1'b1}} >> shamt;
    tick      = run && (cnt_q == cnt_limit);
  end

  always_comb begin
    cnt_en = run || (cnt_q != '0);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/serchan_shifter.sv
module serchan_shifter #(
  parameter int DW    = 32,
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_write,
  input  logic [LEN_W-1:0] len_m1,
  input  logic [DW-1:0]    tx_word,
  input  logic             tick,
  input  logic             miso,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             mosi,
  output logic [DW-1:0]    rx_word
);
  localparam int BITS_W = $clog2(DW + 1);

  logic              busy_q, busy_d;
  logic              sclk_q, sclk_d;
  logic              wr_q, wr_d;
  logic [DW-1:0]     tx_q, tx_d;
  logic [DW-1:0]     rx_q, rx_d;
  logic [BITS_W-1:0] left_q, left_d;
  logic [BITS_W-1:0] sham_q, sham_d;
  logic [LEN_W:0]    nbytes;
  logic [BITS_W-1:0] nbits_new;
  logic              edge_rise, edge_fall, last_fall, upd_en;

  always_comb begin
    nbytes    = {1'b0, len_m1} + 1'b1;
    nbits_new = BITS_W'(nbytes) << 3;
    edge_rise = busy_q && tick && !sclk_q;
    edge_fall = busy_q && tick && sclk_q;
    last_fall = edge_fall && (left_q == BITS_W'(1));
    upd_en    = start || edge_rise || edge_fall;
  end

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    wr_d   = wr_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    left_d = left_q;
    sham_d = sham_q;
    if (start) begin
      busy_d = 1'b1;
      sclk_d = 1'b0;
      wr_d   = is_write;
      tx_d   = tx_word;
      rx_d   = '0;
      left_d = nbits_new;
      sham_d = BITS_W'(DW) - nbits_new;
    end else if (edge_rise) begin
      sclk_d = 1'b1;
      rx_d   = {rx_q[DW-2:0], miso};
    end else if (edge_fall) begin
      sclk_d = 1'b0;
      tx_d   = {tx_q[DW-2:0], 1'b0};
      left_d = left_q - 1'b1;
      if (last_fall) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      wr_q   <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      left_q <= '0;
      sham_q <= '0;
    end else if (upd_en) begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      wr_q   <= wr_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      left_q <= left_d;
      sham_q <= sham_d;
    end
  end

  assign busy    = busy_q;
  assign done    = last_fall;
  assign sclk    = sclk_q;
  assign mosi    = busy_q && wr_q && tx_q[DW-1];
  assign rx_word = rx_q << sham_q;
endmodule

// File: rtl/serchan_regs.sv
module serchan_regs
  import serchan_pkg::*;
#(
  parameter int DW     = 32,
  parameter int NDEV   = 3,
  parameter int RATE_W = 3,
  parameter int ADDR_W = 5,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              xfer_busy,
  input  logic              xfer_done,
  input  logic [DW-1:0]     rx_word,
  output logic [NDEV-1:0]   sel_q,
  output logic [RATE_W-1:0] rate_q,
  output logic              start_pulse,
  output logic              dir_wr,
  output logic [LEN_W-1:0]  len_q,
  output logic [DW-1:0]     data_q
);
  logic              hit_stat, hit_ctrl, hit_data;
  logic [NDEV-1:0]   sel_new, sel_d;
  logic              sel_ok;
  logic [RATE_W-1:0] rate_d;
  logic [DIR_W-1:0]  dir_q, dir_d;
  logic [LEN_W-1:0]  len_d;
  logic [DW-1:0]     data_d;
  logic              stat_en, ctrl_en, data_en, rx_land;

  always_comb begin
    hit_stat    = bus_addr == ADDR_W'(OFS_STAT);
    hit_ctrl    = bus_addr == ADDR_W'(OFS_CTRL);
    hit_data    = bus_addr == ADDR_W'(OFS_DATA);
    sel_new     = bus_wdata[SEL_LSB +: NDEV];
    sel_ok      = (sel_new & (sel_new - 1'b1)) == '0;
    stat_en     = bus_we && hit_stat;
    ctrl_en     = bus_we && hit_ctrl && !xfer_busy;
    start_pulse = ctrl_en && bus_wdata[GO_BIT];
    rx_land     = xfer_done && (dir_q != DIR_TX);
    data_en     = rx_land || (bus_we && hit_data);
  end

  always_comb begin
    sel_d  = sel_ok ? sel_new : sel_q;
    rate_d = bus_wdata[RATE_LSB +: RATE_W];
    dir_d  = bus_wdata[DIR_LSB +: DIR_W];
    len_d  = bus_wdata[LEN_LSB +: LEN_W];
    data_d = rx_land ? rx_word : bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      rate_q <= '0;
    end else if (stat_en) begin
      sel_q  <= sel_d;
      rate_q <= rate_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      len_q <= '0;
    end else if (ctrl_en) begin
      dir_q <= dir_d;
      len_q <= len_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign dir_wr = dir_q == DIR_TX;

  always_comb begin
    bus_rdata = '0;
    if (hit_stat) begin
      bus_rdata[SEL_LSB +: NDEV]    = sel_q;
      bus_rdata[RATE_LSB +: RATE_W] = rate_q;
    end else if (hit_ctrl) begin
      bus_rdata[GO_BIT]             = xfer_busy;
      bus_rdata[DIR_LSB +: DIR_W]   = dir_q;
      bus_rdata[LEN_LSB +: LEN_W]   = len_q;
    end else if (hit_data) begin
      bus_rdata = data_q;
    end
  end
endmodule

// File: rtl/serchan_top.sv
module serchan_top #(
  parameter int DW       = 32,
  parameter int NDEV     = 3,
  parameter int RATE_W   = 3,
  parameter int MAX_CODE = 6,
  parameter int ADDR_W   = 5,
  parameter int LEN_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NDEV-1:0]   dev_sel,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  logic              rst_i_n;
  logic              xfer_busy, xfer_done, start_pulse, dir_wr, tick;
  logic [RATE_W-1:0] rate_q;
  logic [LEN_W-1:0]  len_q;
  logic [DW-1:0]     data_q, rx_word;

  serchan_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  serchan_regs #(
    .DW(DW), .NDEV(NDEV), .RATE_W(RATE_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .xfer_busy   (xfer_busy),
    .xfer_done   (xfer_done),
    .rx_word     (rx_word),
    .sel_q       (dev_sel),
    .rate_q      (rate_q),
    .start_pulse (start_pulse),
    .dir_wr      (dir_wr),
    .len_q       (len_q),
    .data_q      (data_q)
  );

  serchan_clkgen #(
    .RATE_W(RATE_W), .MAX_CODE(MAX_CODE)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_i_n),
    .run   (xfer_busy),
    .rate  (rate_q),
    .tick  (tick)
  );

  serchan_shifter #(
    .DW(DW), .LEN_W(LEN_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .start    (start_pulse),
    .is_write (bus_wdata[2] && !bus_wdata[3]),
    .len_m1   (bus_wdata[4 +: LEN_W]),
    .tx_word  (data_q),
    .tick     (tick),
    .miso     (miso),
    .busy     (xfer_busy),
    .done     (xfer_done),
    .sclk     (sclk),
    .mosi     (mosi),
    .rx_word  (rx_word)
  );

  logic unused_dir;
  assign unused_dir = dir_wr;
endmodule

// File: rtl/serchan_chk.sv
module serchan_chk
  import serchan_pkg::*;
#(
  parameter int DW     = 32,
  parameter int NDEV   = 3,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [NDEV-1:0]   dev_sel,
  input logic              sclk,
  input logic              mosi,
  input logic              xfer_busy
);
  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_sel));

  // R3
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_busy |-> !sclk);

  // R3
  sclk_rise_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> xfer_busy);

  // R6
  mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));

  // R4
  start_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_busy) |-> ($past(bus_we) && ($past(bus_addr) == ADDR_W'(OFS_CTRL))
                          && $past(bus_wdata[GO_BIT])));
endmodule

bind serchan_top serchan_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .dev_sel   (dev_sel),
  .sclk      (sclk),
  .mosi      (mosi),
  .xfer_busy (xfer_busy)
);

// File: tb/sim_serchan_top.sv
module sim_serchan_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;
  localparam logic [4:0] A_STAT = 5'h00, A_BLKA = 5'h04, A_BLKL = 5'h08,
                         A_CTRL = 5'h0C, A_DATA = 5'h10, A_HOLE = 5'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  dev_sel;
  logic        sclk, mosi, miso;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // device model
  logic [31:0] s_pat = '0;
  logic        s_clr = 1'b0;
  logic [5:0]  s_idx = '0;
  logic [31:0] s_rx = '0;
  int          s_rises = 0;
  logic        s_mosi_hi = 1'b0;
  logic        s_prev = 1'b0;
  int          cyc = 0;
  int          t1 = 0, t2 = 0;

  serchan_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_sel(dev_sel),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  assign miso = (s_idx < 6'd32) ? s_pat[5'd31 - s_idx[4:0]] : 1'b0;

  always @(negedge clk) begin
    if (s_clr) begin
      s_idx <= '0; s_rx <= '0; s_rises <= 0; s_mosi_hi <= 1'b0;
    end else begin
      if (sclk && !s_prev) begin
        s_rx <= {s_rx[30:0], mosi};
        s_rises <= s_rises + 1;
        if (mosi) s_mosi_hi <= 1'b1;
        if (s_rises == 0) t1 <= cyc;
        else if (s_rises == 1) t2 <= cyc;
      end
      if (!sclk && s_prev) s_idx <= s_idx + 1'b1;
    end
    s_prev <= sclk;
    cyc <= cyc + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic int eff_code(input logic [2:0] rate);
    return (rate > 3'd6) ? 6 : int'(rate);
  endfunction

  function automatic int nbits_of(input logic [1:0] lenm1);
    return (int'(lenm1) + 1) * 8;
  endfunction

  function automatic logic [31:0] left_just(input logic [31:0] w, input int nb);
    return (w >> (32 - nb)) << (32 - nb);
  endfunction

  task automatic run_xfer(input bit wr, input logic [1:0] lenm1, input logic [2:0] rate,
                          input int dev, input logic [31:0] word, input logic [31:0] pat,
                          input bit intrude);
    logic [31:0] ctrl, rd;
    int cnt, nb, per;
    nb = nbits_of(lenm1);
    per = 2 << eff_code(rate);
    s_pat = pat;
    reg_wr(A_STAT, (32'd1 << (7 + dev)) | (32'(rate) << 4));
    reg_wr(A_DATA, word);
    @(posedge clk); s_clr = 1'b1;
    @(posedge clk); s_clr = 1'b0;
    ctrl = (32'(lenm1) << 4) | (wr ? 32'h4 : 32'h0) | 32'h1;
    @(negedge clk);
    bus_we = 1'b1; bus_addr = A_CTRL; bus_wdata = ctrl;
    @(negedge clk);
    bus_we = 1'b0;
    cnt = 0;
    #1;
    while (bus_rdata[0] && cnt < 20000) begin
      cnt++;
      if (intrude && cnt == 2) begin
        bus_we = 1'b1; bus_wdata = 32'h0000_0035;
      end else bus_we = 1'b0;
      @(negedge clk);
      #1;
    end
    bus_we = 1'b0;
    check("R4 busy cycles", cnt, nb * per);
    check("R3 sclk period", t2 - t1, per);
    check("R3 sclk idle low", {31'd0, sclk}, 32'd0);
    if (wr) begin
      check("R6 bits sent msb first", s_rx, word >> (32 - nb));
    end else begin
      reg_rd(A_DATA, rd);
      check("R7 received word left-justified", rd, left_just(pat, nb));
      check("R7 mosi low in read", {31'd0, s_mosi_hi}, 32'd0);
    end
    reg_rd(A_CTRL, rd);
    check(intrude ? "R8 fields unchanged" : "R5 control readback", rd, ctrl & ~32'h1);
    check("R2 select held", {29'd0, dev_sel}, 32'd1 << dev);
    if (intrude) begin
      repeat (20) @(negedge clk);
      reg_rd(A_CTRL, rd);
      check("R8 no restart", {31'd0, rd[0]}, 32'd0);
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d", WD_CYCLES, WD_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1
    reg_rd(A_STAT, rd); check("R1 status reset", rd, 32'd0);
    reg_rd(A_CTRL, rd); check("R1 control reset", rd, 32'd0);
    reg_rd(A_DATA, rd); check("R1 data reset", rd, 32'd0);
    check("R1 pins reset", {29'd0, dev_sel, sclk, mosi}, 32'd0);

    // R2
    reg_wr(A_STAT, 32'h0000_0100);
    check("R2 select bit8", {29'd0, dev_sel}, 32'd2);
    reg_wr(A_STAT, 32'h0000_01A0);
    check("R2 multi-bit write ignored", {29'd0, dev_sel}, 32'd2);
    reg_rd(A_STAT, rd); check("R3 rate readback", rd, 32'h0000_0120);
    reg_wr(A_STAT, 32'h0000_0000);
    check("R2 zero deselects", {29'd0, dev_sel}, 32'd0);

    // R9
    reg_wr(A_BLKA, 32'hFFFF_FFFF);
    reg_rd(A_BLKA, rd); check("R9 block address inert", rd, 32'd0);
    reg_wr(A_BLKL, 32'hFFFF_FFFF);
    reg_rd(A_BLKL, rd); check("R9 block length inert", rd, 32'd0);
    reg_rd(A_HOLE, rd); check("R9 undecoded zero", rd, 32'd0);
    reg_wr(A_DATA, 32'hA5C3_0F96);
    reg_rd(A_DATA, rd); check("R9 data readback", rd, 32'hA5C3_0F96);

    // directed corners: slowest code and clamped code
    run_xfer(1'b1, 2'd0, 3'd6, 0, 32'hB400_0000, 32'h0, 1'b0);
    run_xfer(1'b0, 2'd0, 3'd7, 2, 32'hFFFF_FFFF, 32'h6E00_0000, 1'b0);
    // command then answer within one selection
    run_xfer(1'b1, 2'd1, 3'd0, 1, 32'h0000_FFFF, 32'h0, 1'b0);
    run_xfer(1'b0, 2'd3, 3'd0, 1, 32'h0, 32'h8000_0001, 1'b0);
    // R8 start while busy
    run_xfer(1'b1, 2'd0, 3'd1, 0, 32'h5A00_0000, 32'h0, 1'b1);

    for (int i = 0; i < 30; i++) begin
      logic [1:0] lm;
      case ($urandom % 3)
        0: lm = 2'd0;
        1: lm = 2'd1;
        default: lm = 2'd3;
      endcase
      run_xfer(1'($urandom % 2), lm, 3'($urandom % 4), int'($urandom % 3),
               $urandom, $urandom, 1'b0);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule